// File: doc/BRIEF.md
# 16-bit Reload Timer/Counter with External Trigger

This block is a 16-bit up-counter that either counts prescaled clock ticks or falling edges on an external count pin. In auto-reload mode it restarts from a programmable reload value whenever it rolls over from FFFFh. When a control bit allows it, a falling edge on a second external pin also forces that reload. Every such external reload sets a sticky flag. Each overflow sets another sticky flag. Either flag can raise an interrupt request.

Software reaches the block through a small byte-wide register port. It holds the control byte, the two counter bytes and the two reload bytes. Both external pins are asynchronous to the clock. They pass through a two-flop synchronizer before their falling edges are detected, so the block reacts a few cycles after a pin moves.

Top module: `reload_timer16`

## Requirements
- R1: After reset the control byte, counter and reload value read 0, and `irq`, `ovf_flag` and `reg_rdata` are 0.
- R2: The register address selects the register: 0 is the control byte, 1 the counter low byte, 2 the counter high byte, 3 the reload low byte and 4 the reload high byte. Any other address reads 0. `reg_rdata` shows the addressed register one clock after the address is presented.
- R3: The control byte has these bits: bit0 auto-reload mode, bit1 count source, bit2 run, bit3 trigger enable, bit4 interrupt enable, bit5 fast prescale, bit6 trigger flag, bit7 overflow flag. With bit2=1 and bit1=0, the counter advances once every 12 clocks, or once every 4 clocks when bit5=1. The first step comes 12 (or 4) clocks after the run bit is written.
- R4: With bit2=1 and bit1=1, the counter advances by one for each 1-to-0 transition on `cnt_pin`. A 0-to-1 transition does not advance it.
- R5: With bit0=1, an advance from FFFFh loads the reload value into the counter and sets bit7.
- R6: With bit0=0, an advance from FFFFh wraps the counter to 0000h and sets bit7.
- R7: With bit0=1 and bit3=1, a 1-to-0 transition on `trg_pin` loads the counter from the reload value and sets bit6. This happens whether or not the run bit is set.
- R8: With bit3=0, or with bit0=0, a transition on `trg_pin` changes neither the counter nor bit6.
- R9: Bits 6 and 7 stay set until software writes 0 to them in the control byte. Writing 1 to either bit never sets it.
- R10: `irq` is a register that goes high one clock after bit4 and at least one of bits 6 and 7 are all 1. It stays low while bit4 is 0. `ovf_flag` mirrors bit7.
- R11: A software write to a counter byte in the same clock as an advance or a reload takes effect in place of that advance or reload.
- R12: With bit2=0 the counter holds its value, apart from software writes and trigger reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pin | input | 1 | Asynchronous external count pin; falling edges are counted |
| trg_pin | input | 1 | Asynchronous external reload trigger pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ovf_flag | output | 1 | Overflow flag (control bit7) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bound checker watches on every cycle that both flags stay sticky, and that `irq` never rises without the enable bit. It also checks that an enabled trigger edge reloads the counter and sets bit6, that a disabled trigger leaves bit6 clear, and that a stopped counter holds. It checks that a counter-byte write always lands. The exact prescale rates, the overflow values in both modes, the edge counting and the cycle on which a software write and a pin edge collide all depend on the counts the bench works out for itself. Only the bench's directed scenarios and vector table can show these.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int BYTE_W   = 8;
  localparam int CB_MODE  = 0;
  localparam int CB_SRC   = 1;
  localparam int CB_RUN   = 2;
  localparam int CB_EXEN  = 3;
  localparam int CB_IEN   = 4;
  localparam int CB_FAST  = 5;
  localparam int CB_EXF   = 6;
  localparam int CB_OVF   = 7;
  localparam int CTRL_SEL = 0;
endpackage

// File: rtl/rtmr_pin_sync.sv
module rtmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  // sh[STAGES-1] is the synchronized sample, sh[STAGES] the previous one
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/rtmr_prescale.sv
module rtmr_prescale #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int PW = $clog2(DIV_SLOW);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  assign lim  = fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  assign tick = run && (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)    pre_q <= '0;
    else if (pre_q == lim) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/rtmr_count_core.sv
module rtmr_count_core #(
  parameter int CNT_W = 16,
  parameter int BW    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               ext_reload,
  input  logic               reload_mode,
  input  logic [CNT_W/BW-1:0] wr_cnt_lane,
  input  logic [CNT_W/BW-1:0] wr_rld_lane,
  input  logic [BW-1:0]      wdata,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   rld_q,
  output logic               ovf_evt,
  output logic               exf_evt
);
  localparam int NB = CNT_W / BW;

  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] rld_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    ovf_evt = 1'b0;
    exf_evt = 1'b0;
    if (ext_reload) begin
      cnt_nxt = rld_q;
      exf_evt = 1'b1;
    end else if (inc) begin
      if (&cnt_q) begin
        ovf_evt = 1'b1;
        cnt_nxt = reload_mode ? rld_q : '0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
    // software byte writes take precedence over hardware updates
    for (int i = 0; i < NB; i++) begin
      if (wr_cnt_lane[i]) cnt_nxt[i*BW +: BW] = wdata;
    end
  end

  always_comb begin
    rld_nxt = rld_q;
    for (int i = 0; i < NB; i++) begin
      if (wr_rld_lane[i]) rld_nxt[i*BW +: BW] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      rld_q <= rld_nxt;
    end
  end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int SYNC_STG = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cnt_pin,
  input  logic        trg_pin,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        ovf_flag,
  output logic        irq
);
  import rtmr_pkg::*;

  localparam int NB    = CNT_W / BYTE_W;
  localparam int NPINS = 2;

  logic [NPINS-1:0]  pin_in;
  logic [NPINS-1:0]  pin_fall;
  logic              trg_fall;
  logic              tick;
  logic              inc;
  logic              ext_reload;
  logic              ovf_evt;
  logic              exf_evt;
  logic              ctrl_wr;
  logic [7:0]        ctrl_q;
  logic [7:0]        ctrl_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  rld_q;
  logic [NB-1:0]     wr_cnt_lane;
  logic [NB-1:0]     wr_rld_lane;
  logic [7:0]        rd_nxt;
  logic [7:0]        rdata_q;
  logic              irq_q;

  assign pin_in   = {trg_pin, cnt_pin};
  assign trg_fall = pin_fall[1];

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    rtmr_pin_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin  (pin_in[g]),
      .fall (pin_fall[g])
    );
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign wr_cnt_lane[i] = reg_wr && (reg_addr == ADDR_W'(1 + i));
    assign wr_rld_lane[i] = reg_wr && (reg_addr == ADDR_W'(1 + NB + i));
  end

  rtmr_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_q[CB_RUN] & ~ctrl_q[CB_SRC]),
    .fast (ctrl_q[CB_FAST]),
    .tick (tick)
  );

  assign inc        = ctrl_q[CB_RUN] & (ctrl_q[CB_SRC] ? pin_fall[0] : tick);
  assign ext_reload = trg_fall & ctrl_q[CB_MODE] & ctrl_q[CB_EXEN];

  rtmr_count_core #(.CNT_W(CNT_W), .BW(BYTE_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .inc         (inc),
    .ext_reload  (ext_reload),
    .reload_mode (ctrl_q[CB_MODE]),
    .wr_cnt_lane (wr_cnt_lane),
    .wr_rld_lane (wr_rld_lane),
    .wdata       (reg_wdata),
    .cnt_q       (cnt_q),
    .rld_q       (rld_q),
    .ovf_evt     (ovf_evt),
    .exf_evt     (exf_evt)
  );

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(CTRL_SEL));

  // flags: software may only clear; a hardware set in the same cycle wins
  always_comb begin
    ctrl_nxt = ctrl_q;
    if (ctrl_wr) begin
      ctrl_nxt         = reg_wdata;
      ctrl_nxt[CB_EXF] = reg_wdata[CB_EXF] & ctrl_q[CB_EXF];
      ctrl_nxt[CB_OVF] = reg_wdata[CB_OVF] & ctrl_q[CB_OVF];
    end
    if (exf_evt) ctrl_nxt[CB_EXF] = 1'b1;
    if (ovf_evt) ctrl_nxt[CB_OVF] = 1'b1;
  end

  always_comb begin
    rd_nxt = '0;
    if (reg_addr == ADDR_W'(CTRL_SEL)) rd_nxt = ctrl_q;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(1 + i))      rd_nxt = cnt_q[i*BYTE_W +: BYTE_W];
      if (reg_addr == ADDR_W'(1 + NB + i)) rd_nxt = rld_q[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nxt;
      rdata_q <= rd_nxt;
      irq_q   <= ctrl_q[CB_IEN] & (ctrl_q[CB_EXF] | ctrl_q[CB_OVF]);
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
  assign ovf_flag  = ctrl_q[CB_OVF];
endmodule

// File: rtl/rtmr_checker.sv
module rtmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             c_mode,
  input logic             c_run,
  input logic             c_exen,
  input logic             c_ien,
  input logic             c_exf,
  input logic             c_ovf,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rld_q,
  input logic             trg_fall,
  input logic             irq
);
  localparam int NB = CNT_W / 8;

  logic ctrl_wr;
  logic cnt_wr;
  logic trig_on;
  assign ctrl_wr = reg_wr && (reg_addr == 3'd0);
  assign cnt_wr  = reg_wr && (reg_addr >= 3'd1) && (reg_addr <= 3'(NB));
  assign trig_on = trg_fall && c_mode && c_exen;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (c_ovf && !ctrl_wr) |=> c_ovf); // R9
  AST_EXF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (c_exf && !ctrl_wr) |=> c_exf); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(c_ien)); // R10
  AST_TRIG_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (trig_on && !cnt_wr) |=> (cnt_q == $past(rld_q)) && c_exf); // R7
  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (trg_fall && !(c_mode && c_exen) && !c_exf) |=> !c_exf); // R8
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!c_run && !cnt_wr && !trig_on) |=> $stable(cnt_q)); // R12
  AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd1) |=> cnt_q[7:0] == $past(reg_wdata)); // R11
endmodule

bind reload_timer16 rtmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .c_mode    (ctrl_q[0]),
  .c_run     (ctrl_q[2]),
  .c_exen    (ctrl_q[3]),
  .c_ien     (ctrl_q[4]),
  .c_exf     (ctrl_q[6]),
  .c_ovf     (ctrl_q[7]),
  .cnt_q     (cnt_q),
  .rld_q     (rld_q),
  .trg_fall  (trg_fall),
  .irq       (irq)
);

// File: tb/tb_reload_timer16.sv
`timescale 1ns/1ps
module tb_reload_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_pin = 1'b1;
  logic       trg_pin = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ovf_flag;
  logic       irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reload_timer16 dut (
    .clk(clk), .rst(rst), .cnt_pin(cnt_pin), .trg_pin(trg_pin),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_flag(ovf_flag), .irq(irq)
  );

  // {fast, cycles between run and stop, expected count}
  localparam int VEC [6][3] = '{
    '{1, 42, 10}, '{0, 42, 3}, '{1, 8, 2},
    '{0, 24, 2},  '{0, 11, 0}, '{1, 3, 0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd1, v[7:0]);
    wr(3'd2, v[15:8]);
  endtask

  task automatic pulse_cnt();
    cnt_pin = 1'b0; repeat (2) @(negedge clk);
    cnt_pin = 1'b1; repeat (2) @(negedge clk);
  endtask

  task automatic pulse_trg();
    trg_pin = 1'b0; repeat (2) @(negedge clk);
    trg_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 ovf_flag", {15'd0, ovf_flag}, 16'd0);
    check("R1 rdata", {8'd0, reg_rdata}, 16'd0);
    rd(3'd0, b); check("R1 ctrl", {8'd0, b}, 16'd0);
    rd_cnt(v);   check("R1 counter", v, 16'd0);
    rd(3'd3, b); check("R1 reload", {8'd0, b}, 16'd0);

    // R2 map and readback
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    rd(3'd3, b); check("R2 reload lo", {8'd0, b}, 16'h0034);
    rd(3'd4, b); check("R2 reload hi", {8'd0, b}, 16'h0012);
    rd(3'd7, b); check("R2 unmapped", {8'd0, b}, 16'd0);

    // R3 prescaled timer mode, vector table
    for (int k = 0; k < 6; k++) begin
      wr(3'd0, 8'h00);
      set_cnt(16'h0000);
      wr(3'd0, (VEC[k][0] != 0) ? 8'h24 : 8'h04);
      repeat (VEC[k][1] - 1) @(negedge clk);
      wr(3'd0, 8'h00);
      rd_cnt(v);
      check($sformatf("R3 vec%0d", k), v, 16'(VEC[k][2]));
    end

    // R4 external count edges
    set_cnt(16'h0000);
    wr(3'd0, 8'h06);
    repeat (3) pulse_cnt();
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h00);
    rd_cnt(v); check("R4 three edges", v, 16'd3);

    // R5 overflow with auto-reload
    set_cnt(16'hFFFE);
    wr(3'd0, 8'h25);
    repeat (7) @(negedge clk);
    wr(3'd0, 8'hC1);
    rd_cnt(v); check("R5 reloaded", v, 16'h1234);
    rd(3'd0, b); check("R5 ctrl ovf", {8'd0, b}, 16'h0081);
    check("R10 ovf_flag", {15'd0, ovf_flag}, 16'd1);
    check("R10 irq masked", {15'd0, irq}, 16'd0);

    // R10 interrupt, R9 clear and no-set
    wr(3'd0, 8'h91);
    @(negedge clk);
    check("R10 irq raised", {15'd0, irq}, 16'd1);
    wr(3'd0, 8'h11);
    @(negedge clk);
    check("R9 ovf cleared", {15'd0, ovf_flag}, 16'd0);
    check("R10 irq dropped", {15'd0, irq}, 16'd0);
    wr(3'd0, 8'h51);
    rd(3'd0, b); check("R9 write 1 no set", {8'd0, b}, 16'h0011);

    // R6 overflow wrap without reload
    wr(3'd0, 8'h00);
    set_cnt(16'hFFFF);
    wr(3'd0, 8'h24);
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h80);
    rd_cnt(v); check("R6 wrap", v, 16'h0000);
    check("R6 ovf", {15'd0, ovf_flag}, 16'd1);
    wr(3'd0, 8'h00);

    // R7 trigger reload while stopped
    wr(3'd3, 8'hCD); wr(3'd4, 8'hAB);
    set_cnt(16'h0050);
    wr(3'd0, 8'h09);
    pulse_trg();
    rd_cnt(v); check("R7 trigger reload", v, 16'hABCD);
    rd(3'd0, b); check("R7 ctrl exf", {8'd0, b}, 16'h0049);

    // R8 trigger ignored
    wr(3'd0, 8'h01);
    set_cnt(16'h0050);
    pulse_trg();
    rd_cnt(v); check("R8 no enable cnt", v, 16'h0050);
    rd(3'd0, b); check("R8 no enable flag", {8'd0, b}, 16'h0001);
    wr(3'd0, 8'h08);
    pulse_trg();
    rd_cnt(v); check("R8 no mode cnt", v, 16'h0050);
    rd(3'd0, b); check("R8 no mode flag", {8'd0, b}, 16'h0008);

    // R11 write collides with a counted edge
    wr(3'd0, 8'h00);
    set_cnt(16'h0100);
    wr(3'd0, 8'h06);
    cnt_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    wr(3'd1, 8'h77);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h00);
    rd_cnt(v); check("R11 write wins", v, 16'h0177);

    // R12 stopped counter holds
    set_cnt(16'h0005);
    repeat (30) @(negedge clk);
    rd_cnt(v); check("R12 timer stopped", v, 16'h0005);
    wr(3'd0, 8'h02);
    pulse_cnt();
    repeat (3) @(negedge clk);
    rd_cnt(v); check("R12 edges stopped", v, 16'h0005);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule